// File: doc/BRIEF.md
# Tagged receive FIFO with threshold request

This block buffers the characters delivered by one serial receiver. Each character is stored together with four tag bits: parity error, framing error, break and overrun. Software or a bus bridge pulls entries out one at a time through a pop strobe. The popped entry is returned as a 16-bit word with a fixed layout. The current number of stored characters is always visible on an occupancy output.

A 2-bit trigger code picks one of three fill levels, or turns threshold signalling off. When the occupancy reaches the selected level and the receive interrupt enable is set, the block raises a receive-data request flag. A receive enable input gates the acceptance of new characters. A flush input empties the buffer for as long as it is held high.

If a character arrives while the buffer is full, that character is lost. The loss is recorded by setting the overrun tag on the most recently stored entry.

Top module: `rx_tag_fifo`

## Requirements
- R1: Entries leave in arrival order. One cycle after an accepted pop, `rd_word` holds the character in bits 7:0, parity error in bit 8, overrun in bit 9, framing error in bit 10 and break in bit 11. Bits 15:12 are zero. `rd_word` keeps that value until the next pop.
- R2: After each clock edge, `rd_count` equals the number of accepted writes minus the number of successful pops. A write and a pop in the same cycle leave the count unchanged.
- R3: The buffer holds DEPTH characters (512 by default), and `rd_count` never exceeds DEPTH.
- R4: A write while the count equals DEPTH is dropped, even if a pop happens in the same cycle. It sets bit 9 (overrun) of the newest stored entry and leaves every other entry unchanged.
- R5: A pop while the buffer is empty loads zero into `rd_word` and leaves the count unchanged. A write in that same cycle is still stored.
- R6: While `flush` is high, the count is zero, writes are ignored and a pop returns zero. Once `flush` is low again, writes are stored normally.
- R7: While `rx_enable` is low, writes are ignored: no entry is stored and no overrun mark is made.
- R8: `trig_sel` code 0 disables the request. Code 1 gives a threshold of 1 character, code 2 gives DEPTH/2 (256), and code 3 gives DEPTH-DEPTH/8 (448). With `rx_irq_en` high, `rx_data_req` is high exactly when the count is at or above the selected threshold.
- R9: With `rx_irq_en` low, `rx_data_req` stays low whatever the count.
- R10: After reset, the count is zero, `rd_word` is zero and `rx_data_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Receiver presents a character this cycle |
| wr_char | input | 8 | Received character |
| wr_parity_err | input | 1 | Parity error tag |
| wr_frame_err | input | 1 | Framing error tag |
| wr_break | input | 1 | Break tag |
| wr_overrun | input | 1 | Overrun tag from the receiver |
| rx_enable | input | 1 | Accept new characters when high |
| flush | input | 1 | Empty the buffer while high |
| rd_pop | input | 1 | Pop strobe |
| rd_word | output | 16 | Last popped word |
| rd_count | output | $clog2(DEPTH+1) | Current occupancy |
| trig_sel | input | 2 | Threshold select code |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rx_data_req | output | 1 | Receive-data request flag |

## Verification
The bench builds the block with DEPTH=16. That gives thresholds of 1, 8 and 14, so a full buffer and overflow are reached within a few cycles. For every trigger code, the bench walks the occupancy through every value from empty to full, checking the request flag at each step against the threshold it computes itself. Each pass then overfills the buffer and drains it completely, comparing every popped word with a queue model. The bench also exercises the corner cases with only a handful of entries in the buffer: simultaneous write and pop, a pop on an empty buffer, flush and the enable gates.

// File: rtl/rx_tag_fifo_pkg.sv
package rx_tag_fifo_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       ovr;
        logic       par;
        logic [7:0] ch;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);
    localparam int WORD_W  = 16;
    localparam int OVR_BIT = 9;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_ONE  = 2'd1,
        TRIG_HALF = 2'd2,
        TRIG_HIGH = 2'd3
    } trig_code_e;

endpackage

// File: rtl/rtf_store.sv
module rtf_store
    import rx_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  rx_entry_t       wdata,
    input  logic            mark_en,
    input  logic [AW-1:0]   mark_addr,
    input  logic [AW-1:0]   raddr,
    output rx_entry_t       rdata
);

    rx_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (mark_en) begin
            mem_q[mark_addr].ovr <= 1'b1;
        end
    end

    assign rdata = mem_q[raddr];

    // the store never sees both ports on one cycle: a mark only happens when full
    AST_WRITE_MARK_EXCL: assert property (@(posedge clk) !(we && mark_en)); // R4

endmodule

// File: rtl/rtf_ctrl.sv
module rtf_ctrl
    import rx_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  rx_entry_t       wr_entry,
    input  logic            rx_enable,
    input  logic            flush,
    input  logic            rd_pop,
    input  rx_entry_t       mem_rdata,
    output logic            mem_we,
    output logic [AW-1:0]   mem_waddr,
    output rx_entry_t       mem_wdata,
    output logic            mark_en,
    output logic [AW-1:0]   mark_addr,
    output logic [AW-1:0]   mem_raddr,
    output logic [CW-1:0]   count,
    output logic [WORD_W-1:0] word
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0]     wr_ptr;
        logic [AW-1:0]     rd_ptr;
        logic [CW-1:0]     count;
        logic [WORD_W-1:0] word;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic is_full, is_empty, wr_req, accept, drop, pop_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
        return (p == '0) ? LAST_IDX : p - 1'b1;
    endfunction

    always_comb begin
        is_full  = (st_q.count == FULL_CNT);
        is_empty = (st_q.count == '0);
        wr_req   = wr_valid && rx_enable && !flush;
        accept   = wr_req && !is_full;
        drop     = wr_req && is_full;
        pop_ok   = rd_pop && !flush && !is_empty;

        st_d = st_q;
        if (rd_pop) begin
            st_d.word = pop_ok ? {{(WORD_W - ENTRY_W){1'b0}}, mem_rdata} : '0;
        end
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (accept) begin
                st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
            end
            if (pop_ok) begin
                st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            end
            case ({accept, pop_ok})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = accept;
    assign mem_waddr = st_q.wr_ptr;
    assign mem_wdata = wr_entry;
    assign mark_en   = drop;
    assign mark_addr = ptr_dec(st_q.wr_ptr);
    assign mem_raddr = st_q.rd_ptr;
    assign count     = st_q.count;
    assign word      = st_q.word;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && wr_valid && rx_enable && !flush && !rd_pop) |=> count == FULL_CNT); // R4
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && rd_pop && !wr_valid && !flush) |=> (word == '0 && count == '0)); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0); // R6
    AST_RXEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !rd_pop && !flush) |=> $stable(count)); // R7
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rx_enable && !flush && rd_pop && count != '0 && count != FULL_CNT) |=> $stable(count)); // R2

endmodule

// File: rtl/rtf_trigger.sv
module rtf_trigger
    import rx_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    trig_sel,
    input  logic          irq_en,
    output logic          req
);

    localparam logic [CW-1:0] LVL_ONE  = CW'(1);
    localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LVL_HIGH = CW'(DEPTH - DEPTH / 8);

    logic          armed;
    logic [CW-1:0] level;

    always_comb begin
        armed = 1'b1;
        level = LVL_ONE;
        case (trig_code_e'(trig_sel))
            TRIG_ONE:  level = LVL_ONE;
            TRIG_HALF: level = LVL_HALF;
            TRIG_HIGH: level = LVL_HIGH;
            default:   armed = 1'b0;
        endcase
        req = irq_en && armed && (count >= level);
    end

    initial begin
        AST_LEVEL_ORDER: assert (LVL_ONE <= LVL_HALF && LVL_HALF <= LVL_HIGH); // R8
    end

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rx_tag_fifo_pkg::*;
#(
    parameter  int DEPTH = 512,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [7:0]    wr_char,
    input  logic          wr_parity_err,
    input  logic          wr_frame_err,
    input  logic          wr_break,
    input  logic          wr_overrun,
    input  logic          rx_enable,
    input  logic          flush,
    input  logic          rd_pop,
    output logic [15:0]   rd_word,
    output logic [CW-1:0] rd_count,
    input  logic [1:0]    trig_sel,
    input  logic          rx_irq_en,
    output logic          rx_data_req
);

    localparam int AW = $clog2(DEPTH);

    rx_entry_t     in_entry, mem_wdata, mem_rdata;
    logic          mem_we, mark_en;
    logic [AW-1:0] mem_waddr, mark_addr, mem_raddr;

    always_comb begin
        in_entry.ch  = wr_char;
        in_entry.par = wr_parity_err;
        in_entry.ovr = wr_overrun;
        in_entry.frm = wr_frame_err;
        in_entry.brk = wr_break;
    end

    rtf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_entry  (in_entry),
        .rx_enable (rx_enable),
        .flush     (flush),
        .rd_pop    (rd_pop),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mark_en   (mark_en),
        .mark_addr (mark_addr),
        .mem_raddr (mem_raddr),
        .count     (rd_count),
        .word      (rd_word)
    );

    rtf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk       (clk),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .mark_en   (mark_en),
        .mark_addr (mark_addr),
        .raddr     (mem_raddr),
        .rdata     (mem_rdata)
    );

    rtf_trigger #(.DEPTH(DEPTH), .CW(CW)) u_trig (
        .count    (rd_count),
        .trig_sel (trig_sel),
        .irq_en   (rx_irq_en),
        .req      (rx_data_req)
    );

    AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_req |-> rd_count != '0); // R8
    AST_REQ_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rx_data_req); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[15:12] == 4'd0); // R1

endmodule

// File: tb/rx_tag_fifo_test.sv
`timescale 1ns/1ps
module rx_tag_fifo_test;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [11:0]   went = '0;
    logic          rx_enable = 1'b1;
    logic          flush = 1'b0;
    logic          rd_pop = 1'b0;
    logic [1:0]    trig_sel = 2'd0;
    logic          rx_irq_en = 1'b0;
    logic [15:0]   rd_word;
    logic [CW-1:0] rd_count;
    logic          rx_data_req;

    int checks = 0;
    int errors = 0;
    logic [11:0] mq[$];
    logic [15:0] exp_word = '0;

    always #2.5 clk = ~clk;

    rx_tag_fifo #(.DEPTH(DEPTH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid      (wr_valid),
        .wr_char       (went[7:0]),
        .wr_parity_err (went[8]),
        .wr_frame_err  (went[10]),
        .wr_break      (went[11]),
        .wr_overrun    (went[9]),
        .rx_enable     (rx_enable),
        .flush         (flush),
        .rd_pop        (rd_pop),
        .rd_word       (rd_word),
        .rd_count      (rd_count),
        .trig_sel      (trig_sel),
        .rx_irq_en     (rx_irq_en),
        .rx_data_req   (rx_data_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int thr(input logic [1:0] s);
        case (s)
            2'd1:    return 1;
            2'd2:    return DEPTH / 2;
            2'd3:    return DEPTH - DEPTH / 8;
            default: return 0;
        endcase
    endfunction

    task automatic step(input logic v, input logic [11:0] e, input logic p, input string tag);
        bit full;
        bit exp_req;
        @(negedge clk);
        wr_valid = v;
        went     = e;
        rd_pop   = p;
        if (flush) begin
            if (p) exp_word = '0;
            mq.delete();
        end else begin
            full = (mq.size() == DEPTH);
            if (p) exp_word = (mq.size() != 0) ? {4'd0, mq.pop_front()} : 16'd0;
            if (v && rx_enable) begin
                if (!full) mq.push_back(e);
                else mq[mq.size() - 1][9] = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        chk(int'(rd_count) == mq.size(), {tag, " count"}, int'(rd_count), mq.size());
        if (p) chk(rd_word == exp_word, {tag, " word"}, int'(rd_word), int'(exp_word));
        exp_req = rx_irq_en && trig_sel != 2'd0 && mq.size() >= thr(trig_sel);
        chk(rx_data_req == exp_req, rx_irq_en ? "R8 req" : "R9 req", int'(rx_data_req), int'(exp_req));
        @(negedge clk);
        wr_valid = 1'b0;
        rd_pop   = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(rd_count == '0, "R10 count", int'(rd_count), 0);
        chk(rd_word == '0, "R10 word", int'(rd_word), 0);
        chk(rx_data_req == 1'b0, "R10 req", int'(rx_data_req), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 R3 R4 R1 R5: sweep every occupancy for each trigger code
        rx_irq_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            for (int i = 0; i < DEPTH; i++)
                step(1'b1, 12'(i * 37 + s * 11 + (i % 16) * 256), 1'b0, "R3 fill");
            step(1'b1, 12'h0AA, 1'b0, "R4 overflow");
            step(1'b1, 12'h055, 1'b1, "R4 overflow with pop");
            for (int i = 0; i < DEPTH; i++)
                step(1'b0, 12'h000, 1'b1, "R1 drain");
            step(1'b0, 12'h000, 1'b1, "R5 empty pop");
        end

        // R9: interrupt enable low masks the request
        rx_irq_en = 1'b0;
        trig_sel  = 2'd1;
        for (int i = 0; i < 4; i++) step(1'b1, 12'(i + 3), 1'b0, "R9 fill");

        // R7: receive enable low ignores writes
        rx_enable = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b1, 12'hF0F, 1'b0, "R7 gated write");
        rx_enable = 1'b1;
        rx_irq_en = 1'b1;

        // R2: simultaneous write and pop
        for (int i = 0; i < 6; i++) step(1'b1, 12'(12'h300 + i), 1'b1, "R2 push pop");

        // R6: flush empties and ignores writes, then normal operation returns
        flush = 1'b1;
        step(1'b1, 12'h123, 1'b0, "R6 flush write");
        step(1'b1, 12'h124, 1'b1, "R6 flush pop");
        flush = 1'b0;
        step(1'b1, 12'h9C5, 1'b0, "R6 after flush");
        step(1'b0, 12'h000, 1'b1, "R6 readback");

        // R5: empty pop with concurrent write stores the write
        step(1'b1, 12'hE71, 1'b1, "R5 empty pop write");
        step(1'b0, 12'h000, 1'b1, "R5 readback");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule